// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block expands a single vector-prefixed scalar integer add into a run of per-element operations on an internal 32-entry, 64-bit register file. Each element reads two sources, adds them and writes the sum to a destination register. The block is given a vector length, a base register and a vector/scalar flag for each of the three operands, and a predicate choice. It steps through the elements one per clock. Vector operands advance one register per element. Scalar operands stay on their base register.

Before each element runs, a predicate decides whether that element writes. The predicate can be a bit mask held in a register (used as stored or inverted), or bits of the condition register (tested for set or for clear). If no predicate is selected, every element runs. A scalar destination ends the run at its first write. A zero vector length ends the run at once.

A simple host port loads and reads the register file while the block is idle. A start/busy/done handshake frames each instruction.

Top module: `vec_elem_seq`

## Requirements
- R1: When `start` is taken with `vlen` = 0, `done` pulses in the next cycle, `busy` never rises and no register is written.
- R2: An operand with its vector flag set uses register (base + i) mod 32 for element i. A source with its flag clear uses its base register for every element.
- R3: With `dst_vec` = 0, the run ends right after the first element that writes, even when `vlen` > 1.
- R4: `pred_mode` = 2'b01 selects the register named by `pred_reg`. Its bit i enables element i; with `pred_inv` = 1, element i is enabled when that bit is 0. Elements 64 and above are disabled. The mask value is taken at start.
- R5: A disabled element leaves its destination unchanged, and an all-zero mask causes no write.
- R6: `pred_mode` = 2'b10 enables element i from the equal flag of condition field 4+i, which is bit 13−4i of `cr_in` (field n holds bits 31−4n down to 28−4n as less, greater, equal, overflow). `pred_inv` = 1 enables the element when that bit is 0. Elements beyond field 7 are disabled. `cr_in` is taken at start.
- R7: Sums are 64 bits and wrap modulo 2^64.
- R8: `busy` is high from the cycle after start and stays high for one cycle per element, whether or not the element is enabled. `done` pulses for one cycle as `busy` falls. A full vector run of length L therefore reports `done` L+1 cycles after start.
- R9: The element counter returns to zero after every instruction, so back-to-back instructions each start from element 0.
- R10: With `vlen` = 1 and all operands scalar, the result equals a plain scalar add.
- R11: A host write while `busy` is high is ignored.
- R12: `pred_mode` 2'b00 or 2'b11 enables every element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the state and the register file |
| start | input | 1 | Begin an instruction (taken when idle) |
| vlen | input | 7 | Vector length |
| dst_base | input | 5 | Destination base register |
| srca_base | input | 5 | First source base register |
| srcb_base | input | 5 | Second source base register |
| dst_vec | input | 1 | Destination is a vector |
| srca_vec | input | 1 | First source is a vector |
| srcb_vec | input | 1 | Second source is a vector |
| pred_mode | input | 2 | 00/11 none, 01 register mask, 10 condition bits |
| pred_inv | input | 1 | Invert the predicate test |
| pred_reg | input | 5 | Register that holds the mask |
| cr_in | input | 32 | Condition register value |
| host_we | input | 1 | Host register write (idle only) |
| host_addr | input | 5 | Host write address |
| host_wdata | input | 64 | Host write data |
| host_raddr | input | 5 | Host read address |
| host_rdata | output | 64 | Host read data (combinational) |
| busy | output | 1 | Elements are being processed |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a run where enabled and disabled elements alternate and the predicate source is itself a register in the same file. The stimulus loads a mask of 0b101 with the host port and runs it twice, first as stored and then inverted, over operands preloaded with distinct values. Sentinel values are placed in the skipped destinations so that a missing write and a stray write can both be seen. A second case writes through the host port while a run is in progress. This checks that the write is refused and that the element cycles still count out.

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int XLEN   = 64,
  parameter int NREG   = 32,
  parameter int AW     = 5,
  parameter int VLW    = 7,
  parameter int CRW    = 32,
  parameter int CRFLD0 = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vlen,
  input  logic [AW-1:0]   dst_base,
  input  logic [AW-1:0]   srca_base,
  input  logic [AW-1:0]   srcb_base,
  input  logic            dst_vec,
  input  logic            srca_vec,
  input  logic            srcb_vec,
  input  logic [1:0]      pred_mode,
  input  logic            pred_inv,
  input  logic [AW-1:0]   pred_reg,
  input  logic [CRW-1:0]  cr_in,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [XLEN-1:0] host_wdata,
  input  logic [AW-1:0]   host_raddr,
  output logic [XLEN-1:0] host_rdata,
  output logic            busy,
  output logic            done
);
  localparam int NFLD = CRW / 4;
  localparam logic [VLW-1:0] ONE = {{(VLW-1){1'b0}}, 1'b1};

  logic [XLEN-1:0] rf [NREG];
  logic            run;
  logic [VLW-1:0]  step;
  logic [VLW-1:0]  vlen_q;
  logic [AW-1:0]   d_q, a_q, b_q;
  logic            dv_q, av_q, bv_q, inv_q;
  logic [1:0]      mode_q;
  logic [XLEN-1:0] mask_q;
  logic [CRW-1:0]  cr_q;

  logic [AW-1:0]   lo, d_idx, a_idx, b_idx;
  logic [XLEN-1:0] sum, msh;
  logic [CRW-1:0]  csh;
  logic            en, last;
  int              fld;

  assign lo    = step[AW-1:0];
  assign d_idx = d_q + (dv_q ? lo : '0);
  assign a_idx = a_q + (av_q ? lo : '0);
  assign b_idx = b_q + (bv_q ? lo : '0);
  assign sum   = rf[a_idx] + rf[b_idx];
  assign host_rdata = rf[host_raddr];
  assign busy  = run;

  always_comb begin
    fld = CRFLD0 + int'(step);
    msh = mask_q >> step;
    csh = '0;
    if (fld < NFLD) csh = cr_q >> (CRW - 3 - 4 * fld);
    case (mode_q)
      2'b01:   en = (int'(step) < XLEN) && (msh[0] ^ inv_q);
      2'b10:   en = (fld < NFLD) && (csh[0] ^ inv_q);
      default: en = 1'b1;
    endcase
  end

  assign last = (step == vlen_q - ONE) || (!dv_q && en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      done   <= 1'b0;
      step   <= '0;
      vlen_q <= '0;
      d_q    <= '0;
      a_q    <= '0;
      b_q    <= '0;
      dv_q   <= 1'b0;
      av_q   <= 1'b0;
      bv_q   <= 1'b0;
      inv_q  <= 1'b0;
      mode_q <= 2'b00;
      mask_q <= '0;
      cr_q   <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (host_we) rf[host_addr] <= host_wdata;
        if (start) begin
          vlen_q <= vlen;
          d_q    <= dst_base;
          a_q    <= srca_base;
          b_q    <= srcb_base;
          dv_q   <= dst_vec;
          av_q   <= srca_vec;
          bv_q   <= srcb_vec;
          inv_q  <= pred_inv;
          mode_q <= pred_mode;
          mask_q <= rf[pred_reg];
          cr_q   <= cr_in;
          step   <= '0;
          if (vlen == '0) done <= 1'b1;
          else            run  <= 1'b1;
        end
      end else begin
        if (en) rf[d_idx] <= sum;
        if (last) begin
          run  <= 1'b0;
          done <= 1'b1;
          step <= '0;
        end else begin
          step <= step + ONE;
        end
      end
    end
  end
endmodule

module vec_elem_seq_chk #(
  parameter int VLW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [VLW-1:0] vlen,
  input logic           busy,
  input logic           done,
  input logic [VLW-1:0] step
);
  // R1
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vlen == '0) |=> (done && !busy));

  // R8
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vlen != '0) |=> busy);

  // R8
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  one_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> (step == $past(step) + 1'b1));

  // R9
  step_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (step == '0 && !busy));
endmodule

bind vec_elem_seq vec_elem_seq_chk #(.VLW(VLW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
  .busy(busy), .done(done), .step(step)
);

// File: tb/vec_elem_seq_tb_top.sv
module vec_elem_seq_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [6:0]  vlen = 0;
  logic [4:0]  dst_base = 0, srca_base = 0, srcb_base = 0;
  logic        dst_vec = 0, srca_vec = 0, srcb_vec = 0;
  logic [1:0]  pred_mode = 0;
  logic        pred_inv = 0;
  logic [4:0]  pred_reg = 0;
  logic [31:0] cr_in = 0;
  logic        host_we = 0;
  logic [4:0]  host_addr = 0, host_raddr = 0;
  logic [63:0] host_wdata = 0, host_rdata;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  int cyc;

  always #2.5 clk = ~clk;

  vec_elem_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen),
    .dst_base(dst_base), .srca_base(srca_base), .srcb_base(srcb_base),
    .dst_vec(dst_vec), .srca_vec(srca_vec), .srcb_vec(srcb_vec),
    .pred_mode(pred_mode), .pred_inv(pred_inv), .pred_reg(pred_reg),
    .cr_in(cr_in), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_raddr(host_raddr),
    .host_rdata(host_rdata), .busy(busy), .done(done)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [63:0] d);
    @(negedge clk);
    host_we = 1; host_addr = 5'(a); host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd_chk(string req, int a, logic [63:0] exp);
    host_raddr = 5'(a);
    #0.1;
    chk(req, host_rdata, exp);
  endtask

  task automatic clear_rf();
    for (int i = 0; i < 32; i++) wr(i, 64'h0);
  endtask

  task automatic run(int vl, int d, int a, int b, bit dv, bit av, bit bv,
                     logic [1:0] md, bit inv, int pr, logic [31:0] cr);
    @(negedge clk);
    vlen = 7'(vl); dst_base = 5'(d); srca_base = 5'(a); srcb_base = 5'(b);
    dst_vec = dv; srca_vec = av; srcb_vec = bv;
    pred_mode = md; pred_inv = inv; pred_reg = 5'(pr); cr_in = cr;
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    chk("R8 reset busy", {63'd0, busy}, 64'd0);
    chk("R8 reset done", {63'd0, done}, 64'd0);
    rd_chk("R1 reset rf", 1, 64'd0);
  endtask

  task automatic t_vector();
    clear_rf();
    wr(9, 64'h1234); wr(10, 64'h1111); wr(5, 64'h4321); wr(6, 64'h2223);
    run(2, 1, 5, 9, 1, 1, 1, 2'b00, 0, 0, 0);
    chk("R8 cycles vl2", 64'(cyc), 64'd3);
    rd_chk("R2 el0", 1, 64'h5555);
    rd_chk("R2 el1", 2, 64'h3334);
  endtask

  task automatic t_scalar();
    clear_rf();
    wr(9, 64'h1234); wr(5, 64'h4321);
    run(1, 1, 5, 9, 0, 0, 0, 2'b00, 0, 0, 0);
    rd_chk("R10 plain add", 1, 64'h5555);
  endtask

  task automatic t_zero();
    clear_rf();
    wr(7, 64'h3012); wr(10, 64'h1230); wr(13, 64'hAAAA);
    run(0, 13, 10, 7, 1, 1, 1, 2'b00, 0, 0, 0);
    chk("R1 vl0 done delay", 64'(cyc), 64'd1);
    rd_chk("R1 vl0 no write", 13, 64'hAAAA);
  endtask

  task automatic t_b2b();
    clear_rf();
    wr(9, 64'h1234); wr(10, 64'h1111); wr(11, 64'h3012);
    wr(5, 64'h4321); wr(6, 64'h2223); wr(7, 64'h1230);
    run(3, 1, 5, 9, 1, 1, 1, 2'b00, 0, 0, 0);
    run(3, 13, 10, 7, 1, 1, 1, 2'b00, 0, 0, 0);
    rd_chk("R9 first r1", 1, 64'h5555);
    rd_chk("R9 first r3", 3, 64'h4242);
    rd_chk("R9 second r13", 13, 64'h2341);
    rd_chk("R9 second r14", 14, 64'h3012);
    rd_chk("R9 second r15", 15, 64'h1234);
  endtask

  task automatic t_scalar_dst();
    clear_rf();
    wr(9, 64'h1234); wr(10, 64'h1111); wr(5, 64'h4321); wr(6, 64'h2223);
    wr(2, 64'hBEEF);
    run(2, 1, 5, 9, 0, 1, 1, 2'b00, 0, 0, 0);
    chk("R3 early end cycles", 64'(cyc), 64'd2);
    rd_chk("R3 r1", 1, 64'h5555);
    rd_chk("R3 r2 untouched", 2, 64'hBEEF);
  endtask

  task automatic t_scalar_src();
    clear_rf();
    wr(9, 64'h1234); wr(10, 64'h1111); wr(5, 64'h4321); wr(6, 64'h2223);
    run(2, 1, 5, 9, 1, 0, 1, 2'b00, 0, 0, 0);
    rd_chk("R2 scalar src el0", 1, 64'h5555);
    rd_chk("R2 scalar src el1", 2, 64'h5432);
  endtask

  task automatic t_intmask();
    clear_rf();
    wr(30, 64'b101);
    wr(9, 64'h1234); wr(10, 64'h1111); wr(11, 64'h3012);
    wr(5, 64'h4321); wr(6, 64'h2223); wr(7, 64'h1230); wr(8, 64'h8051);
    wr(2, 64'hD00D); wr(13, 64'hC0DE); wr(15, 64'hF00D);
    run(3, 1, 5, 9, 1, 1, 1, 2'b01, 0, 30, 0);
    chk("R8 masked cycles", 64'(cyc), 64'd4);
    rd_chk("R4 mask el0", 1, 64'h5555);
    rd_chk("R5 mask el1 kept", 2, 64'hD00D);
    rd_chk("R4 mask el2", 3, 64'h4242);
    run(3, 13, 10, 7, 1, 1, 1, 2'b01, 1, 30, 0);
    rd_chk("R5 inv el0 kept", 13, 64'hC0DE);
    rd_chk("R4 inv el1", 14, 64'hB063);
    rd_chk("R5 inv el2 kept", 15, 64'hF00D);
  endtask

  task automatic t_zeromask();
    clear_rf();
    wr(9, 64'h1234); wr(5, 64'h4321); wr(1, 64'h11); wr(2, 64'h22); wr(3, 64'h33);
    run(3, 1, 5, 9, 1, 1, 1, 2'b01, 0, 30, 0);
    rd_chk("R5 zero mask r1", 1, 64'h11);
    rd_chk("R5 zero mask r2", 2, 64'h22);
    rd_chk("R5 zero mask r3", 3, 64'h33);
  endtask

  task automatic t_crpred();
    clear_rf();
    wr(1, 64'hBEEF);
    wr(9, 64'h1234); wr(10, 64'h1111); wr(5, 64'h4321); wr(6, 64'h2223);
    run(2, 1, 5, 9, 1, 1, 1, 2'b10, 1, 0, 32'h2000);
    rd_chk("R6 ne el0 skipped", 1, 64'hBEEF);
    rd_chk("R6 ne el1", 2, 64'h3334);
    wr(2, 64'h7777);
    run(2, 1, 5, 9, 1, 1, 1, 2'b10, 0, 0, 32'h2000);
    rd_chk("R6 eq el0", 1, 64'h5555);
    rd_chk("R6 eq el1 skipped", 2, 64'h7777);
  endtask

  task automatic t_nopred11();
    clear_rf();
    wr(5, 64'h1); wr(6, 64'h2); wr(9, 64'h10); wr(10, 64'h20);
    run(2, 1, 5, 9, 1, 1, 1, 2'b11, 1, 0, 0);
    rd_chk("R12 mode11 el0", 1, 64'h11);
    rd_chk("R12 mode11 el1", 2, 64'h22);
  endtask

  task automatic t_wrap();
    clear_rf();
    wr(9, 64'hFFFF_FFFF_FFFF_FFFF); wr(5, 64'h1); wr(1, 64'h99);
    run(1, 1, 5, 9, 0, 0, 0, 2'b00, 0, 0, 0);
    rd_chk("R7 wrap", 1, 64'h0);
  endtask

  task automatic t_busywrite();
    clear_rf();
    wr(20, 64'h77);
    @(negedge clk);
    vlen = 7'd3; dst_base = 5'd1; srca_base = 5'd5; srcb_base = 5'd9;
    dst_vec = 1; srca_vec = 1; srcb_vec = 1; pred_mode = 2'b00; pred_inv = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    host_we = 1; host_addr = 5'd20; host_wdata = 64'hDEAD;
    @(negedge clk);
    host_we = 0;
    while (!done) @(negedge clk);
    rd_chk("R11 busy write ignored", 20, 64'h77);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_vector();
    t_scalar();
    t_zero();
    t_b2b();
    t_scalar_dst();
    t_scalar_src();
    t_intmask();
    t_zeromask();
    t_crpred();
    t_nopred11();
    t_wrap();
    t_busywrite();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule